// File: doc/BRIEF.md
# Synchronous FIFO with Reset-Latched Almost Thresholds

This block is a single-clock first-in, first-out buffer that holds 64 words of 36 bits. It has one write port and one read port. It reports four status flags: full, empty, almost-full and almost-empty. The read port works in show-ahead mode, so the oldest stored word is always present on the read data output and a read strobe removes it.

Both almost flags use one shared threshold X. X is one of four preset values. A two-bit select code picks the value, and the block captures that code at the moment reset is released. After that, the select pins have no effect until the next reset. Integrators tie the select pins to a board or strap value, or drive them during reset.

All four flags come from registers. Each flag reflects the stored word count from the clock edge that committed the last operation.

Top module: `fifo_thresh_top`

## Requirements
- R1: Words read out appear in the order they were written, bit for bit, with the 36-bit oldest word shown on `rd_data_o` whenever the FIFO is not empty.
- R2: The select code on `thr_sel_i` is captured on the low-to-high transition of `rst_ni`; changes to it after that transition do not alter any flag behaviour.
- R3: Select code 2'b11 gives X = 16, 2'b10 gives X = 12, 2'b01 gives X = 8 and 2'b00 gives X = 4.
- R4: `almost_empty_o` is high exactly when the stored word count is X or less.
- R5: `almost_full_o` is high exactly when the free space (64 minus count) is X or less.
- R6: A write while `full_o` is high is ignored, and a read while `empty_o` is high is ignored; neither changes the count or the stored data.
- R7: While `rst_ni` is low, the pointers and count clear, `empty_o` and `almost_empty_o` are high, and `full_o` and `almost_full_o` are low. Any previous contents are discarded.
- R8: `full_o` is high exactly when 64 words are stored, and `empty_o` is high exactly when none are stored.
- R9: A simultaneous read and write on a FIFO that is neither empty nor full leaves the count and all flags unchanged, while the data advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset; its rising edge latches the threshold code |
| thr_sel_i | input | 2 | Threshold select code |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 36 | Write data |
| rd_en_i | input | 1 | Read strobe; pops the word shown on rd_data_o |
| rd_data_o | output | 36 | Oldest stored word (show-ahead) |
| full_o | output | 1 | 64 words stored |
| empty_o | output | 1 | No words stored |
| almost_full_o | output | 1 | Free space is X or less |
| almost_empty_o | output | 1 | Count is X or less |

## Verification
Any wrong internal state shows at the ports within one clock edge. A count that is off by one moves an almost flag, or the full or empty flag, at the wrong boundary on the edge that commits the operation. A pointer that slips shows up as a wrong word on `rd_data_o` before the next read. A wrong latched threshold moves the almost-empty edge within X+1 writes after reset. Each code is therefore swept with a full fill and a full drain, so every boundary is crossed in both directions.

// File: rtl/fifo_thresh_pkg.sv
package fifo_thresh_pkg;

  localparam int unsigned THR_SEL_W = 2;

  // threshold step per select code
  localparam int unsigned THR_STEP = 4;

  function automatic int unsigned thr_from_code(input logic [THR_SEL_W-1:0] code);
    return THR_STEP * (int'(code) + 1);
  endfunction

endpackage

// File: rtl/fifo_thr_latch.sv
module fifo_thr_latch
  import fifo_thresh_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [THR_SEL_W-1:0] thr_sel_i,
  output logic [CNT_W-1:0]     thr_o
);

  logic [CNT_W-1:0] thr_q;

  // captured by the release edge of reset itself
  always_ff @(posedge rst_ni) begin
    thr_q <= CNT_W'(thr_from_code(thr_sel_i));
  end

  assign thr_o = thr_q;

  a_r3_thr_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q == CNT_W'(4)) || (thr_q == CNT_W'(8)) ||
    (thr_q == CNT_W'(12)) || (thr_q == CNT_W'(16)));

  a_r2_thr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(thr_q));

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             wr_ok_o,
  output logic [AW-1:0]    wr_ptr_o,
  output logic [AW-1:0]    rd_ptr_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             almost_full_o,
  output logic             almost_empty_o
);

  localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, free_d;
  logic             full_q, empty_q, af_q, ae_q;
  logic             wr_ok, rd_ok;

  assign wr_ok = wr_en_i && !full_q;
  assign rd_ok = rd_en_i && !empty_q;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_ok && !rd_ok) cnt_d = cnt_q + 1'b1;
    if (rd_ok && !wr_ok) cnt_d = cnt_q - 1'b1;
    free_d = CAP - cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
      af_q     <= 1'b0;
      ae_q     <= 1'b1;
    end else begin
      if (wr_ok) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_ok) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      cnt_q   <= cnt_d;
      full_q  <= (cnt_d == CAP);
      empty_q <= (cnt_d == '0);
      af_q    <= (free_d <= thr_i);
      ae_q    <= (cnt_d <= thr_i);
    end
  end

  assign wr_ok_o        = wr_ok;
  assign wr_ptr_o       = wr_ptr_q;
  assign rd_ptr_o       = rd_ptr_q;
  assign full_o         = full_q;
  assign empty_o        = empty_q;
  assign almost_full_o  = af_q;
  assign almost_empty_o = ae_q;

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_en_i && !rd_en_i) |=> (full_q && $stable(wr_ptr_q)));

  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_q && rd_en_i && !wr_en_i) |=> (empty_q && $stable(rd_ptr_q)));

  a_r9_count_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_q && !empty_q && wr_en_i && rd_en_i) |=>
      ($stable(cnt_q) && $stable(full_q) && $stable(empty_q)));

  a_r8_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_q && empty_q));

  a_r4_empty_implies_ae: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_q |-> ae_q);

  a_r5_full_implies_af: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> af_q);

endmodule

// File: rtl/fifo_thresh_top.sv
module fifo_thresh_top
  import fifo_thresh_pkg::*;
#(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [THR_SEL_W-1:0] thr_sel_i,
  input  logic                 wr_en_i,
  input  logic [WIDTH-1:0]     wr_data_i,
  input  logic                 rd_en_i,
  output logic [WIDTH-1:0]     rd_data_o,
  output logic                 full_o,
  output logic                 empty_o,
  output logic                 almost_full_o,
  output logic                 almost_empty_o
);

  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CNT_W = AW + 1;

  logic [CNT_W-1:0] thr;
  logic             wr_ok;
  logic [AW-1:0]    wr_ptr, rd_ptr;

  fifo_thr_latch #(.CNT_W(CNT_W)) u_thr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .thr_sel_i (thr_sel_i),
    .thr_o     (thr)
  );

  fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .rd_en_i        (rd_en_i),
    .thr_i          (thr),
    .wr_ok_o        (wr_ok),
    .wr_ptr_o       (wr_ptr),
    .rd_ptr_o       (rd_ptr),
    .full_o         (full_o),
    .empty_o        (empty_o),
    .almost_full_o  (almost_full_o),
    .almost_empty_o (almost_empty_o)
  );

  fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_ok),
    .waddr_i (wr_ptr),
    .wdata_i (wr_data_i),
    .raddr_i (rd_ptr),
    .rdata_o (rd_data_o)
  );

endmodule

// File: tb/fifo_thresh_top_test.sv
module fifo_thresh_top_test;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WIDTH = 36;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned NVEC  = 9;

  // {wr, rd, cycles}
  localparam logic [9:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 8'd20},
    {1'b1, 1'b1, 8'd10},
    {1'b0, 1'b1, 8'd5},
    {1'b1, 1'b0, 8'd52},
    {1'b1, 1'b1, 8'd3},
    {1'b0, 1'b1, 8'd70},
    {1'b1, 1'b1, 8'd4},
    {1'b1, 1'b0, 8'd7},
    {1'b0, 1'b1, 8'd9}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       thr_sel = 2'b00;
  logic             wr_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [WIDTH-1:0] rd_data;
  logic             full, empty, afull, aempty;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  int unsigned wseq   = 0;
  int unsigned thr    = 4;
  logic [WIDTH-1:0] model_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_thresh_top #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .thr_sel_i      (thr_sel),
    .wr_en_i        (wr_en),
    .wr_data_i      (wr_data),
    .rd_en_i        (rd_en),
    .rd_data_o      (rd_data),
    .full_o         (full),
    .empty_o        (empty),
    .almost_full_o  (afull),
    .almost_empty_o (aempty)
  );

  function automatic logic [WIDTH-1:0] pattern(input int unsigned n);
    logic [31:0] lo;
    lo = n * 32'h9E37_79B1;
    return {n[3:0], lo};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_flags(input string tag);
    int unsigned n;
    n = model_q.size();
    chk(empty === (n == 0), {tag, "/R8 empty"}, WIDTH'(empty), WIDTH'(n == 0));
    chk(full === (n == DEPTH), {tag, "/R8 full"}, WIDTH'(full), WIDTH'(n == DEPTH));
    chk(aempty === (n <= thr), {tag, "/R4 almost_empty"}, WIDTH'(aempty), WIDTH'(n <= thr));
    chk(afull === ((DEPTH - n) <= thr), {tag, "/R5 almost_full"},
        WIDTH'(afull), WIDTH'((DEPTH - n) <= thr));
  endtask

  task automatic step(input bit wr, input bit rd, input string tag);
    bit wacc, racc;
    logic [WIDTH-1:0] wd;
    @(negedge clk);
    wd = pattern(wseq);
    wr_en = wr;
    rd_en = rd;
    wr_data = wd;
    #1;
    if (model_q.size() > 0)
      chk(rd_data === model_q[0], {tag, "/R1 head data"}, rd_data, model_q[0]);
    wacc = wr && (model_q.size() < DEPTH);
    racc = rd && (model_q.size() > 0);
    @(posedge clk);
    #1;
    if (racc) void'(model_q.pop_front());
    if (wacc) begin
      model_q.push_back(wd);
      wseq++;
    end
    check_flags(tag);
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    thr_sel = code;
    rst_ni = 1'b0;
    @(negedge clk);
    #1;
    // R7 reset state
    chk(empty === 1'b1, "R7 empty in reset", WIDTH'(empty), WIDTH'(1));
    chk(aempty === 1'b1, "R7 almost_empty in reset", WIDTH'(aempty), WIDTH'(1));
    chk(full === 1'b0, "R7 full in reset", WIDTH'(full), WIDTH'(0));
    chk(afull === 1'b0, "R7 almost_full in reset", WIDTH'(afull), WIDTH'(0));
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R2: later changes on the select pins must be ignored
    thr_sel = ~code;
    // R3 code map
    thr = 4 * (int'(code) + 1);
    model_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    do_reset(2'b01);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int c = 0; c < int'(VECS[v][7:0]); c++)
        step(VECS[v][9], VECS[v][8], "VEC");
    end

    // R7: reset with data present discards contents
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R7 prefill");
    do_reset(2'b10);
    step(1'b0, 1'b0, "R7 after reset");
    step(1'b0, 1'b1, "R6 read on empty");

    // R3/R4/R5/R2: sweep each code through full fill and drain
    for (int code = 0; code < 4; code++) begin
      do_reset(2'(code));
      for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, "R3 fill");
      step(1'b1, 1'b0, "R6 write on full");
      step(1'b1, 1'b0, "R6 write on full");
      for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, "R3 drain");
      step(1'b0, 1'b1, "R6 read on empty");
    end

    // R9: simultaneous traffic in mid range, and at one from each edge
    do_reset(2'b11);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, "R9 setup");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, "R9 mid");
    for (int i = 0; i < 33; i++) step(1'b1, 1'b0, "R9 setup");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, "R9 near full");
    step(1'b1, 1'b0, "R8 reach full");
    step(1'b1, 1'b1, "R6 both on full");
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, "R1 drain");
    step(1'b1, 1'b1, "R6 both on empty");
    step(1'b1, 1'b1, "R9 single word");
    step(1'b0, 1'b1, "R1 last word");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule